// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-plane combinational logic fabric whose behaviour is set entirely by a configuration word. The first plane builds `N_TERM` product terms. Each term can take any of the `N_IN` inputs in true form, in complemented form, or not at all. The second plane gives each of the `N_OUT` outputs any subset of those terms to OR together. Several outputs may share a single term. A polarity bit per output can invert that output's sum, which lets an output carry a product-of-sums function.

The configuration is shifted in one bit per clock through a serial chain while `cfg_en` is high. A single `cfg_done` pulse then marks it valid. The outputs stay at 0 from reset until the configuration is valid, and they drop to 0 again as soon as a new load begins. After that, the data path from `in_vec` to `out_vec` is purely combinational.

Top module: `pla_fabric`

## Requirements
- R1: The configuration word is CFG_BITS = 2·N_IN·N_TERM + N_TERM·N_OUT + N_OUT bits wide. The first bit shifted in ends up in the most significant position. Each clock with `cfg_en` high shifts `cfg_bit` into bit 0 and moves every other bit up by one position. Field layout, from low bits to high bits:
  - bits [N_OUT-1:0] hold the polarity bits, with bit o for output o;
  - the next N_TERM·N_OUT bits hold the OR plane, with bit N_OUT + o·N_TERM + t connecting term t to output o;
  - the top 2·N_IN·N_TERM bits hold the AND plane, with bit N_OUT + N_TERM·N_OUT + 2·(t·N_IN + i) selecting input i in true form for term t, and the bit one higher selecting its complement.
- R2: A product term is 1 exactly when every literal connected to it holds. A term with both forms of one input connected is therefore always 0.
- R3: A product term with no connected literal is 0, whatever the inputs are.
- R4: While the configuration is valid, output o before polarity is the OR of the terms its OR-plane bits select. A term may feed several outputs, and an output with no term selected sums to 0.
- R5: When the polarity bit of output o is set, the output is the complement of its sum.
- R6: `out_vec` is 0 whenever the configuration is not valid. A clock with `cfg_en` high makes the configuration invalid. A clock with `cfg_done` high and `cfg_en` low makes it valid. After reset it is invalid.
- R7: While `cfg_en` is low, the configuration word keeps its value and `cfg_bit` has no effect.
- R8: With 3 inputs A=in_vec[0], B=in_vec[1], C=in_vec[2], the fabric can be set up as follows:
  - terms AB, BC and AC, plus one empty term;
  - output 0 selecting the three used terms, giving AB + BC + AC;
  - output 1 selecting all four terms with polarity set, giving the complement.

  Both outputs are correct over all 8 input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, first bit is the MSB |
| cfg_done | input | 1 | Pulse that marks the loaded configuration valid |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
The bench builds the fabric with its default sizes of 3 inputs, 4 product terms and 2 outputs. This gives a 34-bit configuration word, so a random configuration fits in two random draws, and all 8 input vectors can be applied to every configuration. That makes exhaustive comparison against a bench-side model possible for each random setup, as well as for the majority/complement reference. Because four terms fit among only two outputs, sharing of terms, empty terms, contradictory literals and unselected outputs all occur often in random configurations, and directed cases also cover them.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // One literal slot: passes when not connected, or when the input matches the chosen form.
  function automatic logic lit_ok(input logic use_true, input logic use_comp, input logic x);
    return (~use_true | x) & (~use_comp | ~x);
  endfunction

  // Total configuration width for a given fabric size.
  function automatic int cfg_width(input int n_in, input int n_term, input int n_out);
    return 2 * n_in * n_term + n_term * n_out + n_out;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic         cfg_done,
  output logic [W-1:0] cfg_word,
  output logic         cfg_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word  <= '0;
      cfg_valid <= 1'b0;
    end else begin
      if (cfg_en) begin
        cfg_word  <= {cfg_word[W-2:0], cfg_bit};
        cfg_valid <= 1'b0;
      end else if (cfg_done) begin
        cfg_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [2*N_IN*N_TERM-1:0] and_cfg,
  output logic [N_TERM-1:0]        term_hit
);

  localparam int SLICE = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] ok;
    logic            used;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign ok[i] = lit_ok(and_cfg[t*SLICE + 2*i], and_cfg[t*SLICE + 2*i + 1], in_vec[i]);
    end
    assign used        = |and_cfg[t*SLICE +: SLICE];
    assign term_hit[t] = used & (&ok);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]       term_hit,
  input  logic [N_TERM*N_OUT-1:0] or_cfg,
  input  logic [N_OUT-1:0]        pol,
  input  logic                    cfg_valid,
  output logic [N_OUT-1:0]        sum_raw,
  output logic [N_OUT-1:0]        out_vec
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sum_raw[o] = |(term_hit & or_cfg[o*N_TERM +: N_TERM]);
    assign out_vec[o] = cfg_valid & (sum_raw[o] ^ pol[o]);
  end

endmodule

// File: rtl/pla_fabric.sv
module pla_fabric
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic             cfg_done,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  localparam int AND_BITS = 2 * N_IN * N_TERM;
  localparam int OR_BITS  = N_TERM * N_OUT;
  localparam int CFG_BITS = cfg_width(N_IN, N_TERM, N_OUT);
  localparam int OR_LSB   = N_OUT;
  localparam int AND_LSB  = N_OUT + OR_BITS;

  logic [CFG_BITS-1:0] cfg_word;
  logic                cfg_valid;
  logic [N_TERM-1:0]   term_hit;
  logic [N_OUT-1:0]    sum_raw;

  pla_cfg_chain #(.W(CFG_BITS)) chain_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .cfg_word(cfg_word), .cfg_valid(cfg_valid)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) and_i (
    .in_vec(in_vec), .and_cfg(cfg_word[AND_LSB +: AND_BITS]), .term_hit(term_hit)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) or_i (
    .term_hit(term_hit), .or_cfg(cfg_word[OR_LSB +: OR_BITS]),
    .pol(cfg_word[N_OUT-1:0]), .cfg_valid(cfg_valid),
    .sum_raw(sum_raw), .out_vec(out_vec)
  );

endmodule

// File: rtl/pla_fabric_chk.sv
module pla_fabric_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int W      = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_bit,
  input logic             cfg_done,
  input logic [W-1:0]     cfg_word,
  input logic             cfg_valid,
  input logic [N_TERM-1:0] term_hit,
  input logic [N_OUT-1:0] out_vec
);

  localparam int AND_LSB = N_OUT + N_TERM * N_OUT;

  a_r1_shift_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[0] == $past(cfg_bit));
  a_r1_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[W-1:1] == $past(cfg_word[W-2:0]));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word));
  a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> out_vec == '0);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> !cfg_valid);
  a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !cfg_en) |=> cfg_valid);

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    a_r3_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[AND_LSB + 2*N_IN*t +: 2*N_IN] == '0) |-> !term_hit[t]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    a_r4_no_terms: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_word[N_OUT + o*N_TERM +: N_TERM] == '0) |-> out_vec[o] == cfg_word[o]);
  end

endmodule

bind pla_fabric pla_fabric_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .W(CFG_BITS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_done(cfg_done),
  .cfg_word(cfg_word), .cfg_valid(cfg_valid), .term_hit(term_hit), .out_vec(out_vec)
);

// File: tb/pla_fabric_tb_top.sv
module pla_fabric_tb_top;

  localparam int NI = 3;
  localparam int NT = 4;
  localparam int NO = 2;
  localparam int CW = 2*NI*NT + NT*NO + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_bit = 1'b0, cfg_done = 1'b0;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] out_vec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pla_fabric #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .in_vec(in_vec), .out_vec(out_vec)
  );

  function automatic int idx_lit(int t, int i, int comp);
    return NO + NT*NO + 2*(t*NI + i) + comp;
  endfunction
  function automatic int idx_sel(int o, int t);
    return NO + o*NT + t;
  endfunction

  // Bench golden model, written from the requirements.
  function automatic logic [NO-1:0] model(logic [CW-1:0] w, logic [NI-1:0] x);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++) begin
      logic s = 1'b0;
      for (int t = 0; t < NT; t++) begin
        bit any = 0, hit = 1;
        for (int i = 0; i < NI; i++) begin
          if (w[idx_lit(t, i, 0)]) begin any = 1; if (!x[i]) hit = 0; end
          if (w[idx_lit(t, i, 1)]) begin any = 1; if (x[i])  hit = 0; end
        end
        if (w[idx_sel(o, t)] && any && hit) s = 1'b1;
      end
      r[o] = w[o] ? ~s : s;
    end
    return r;
  endfunction

  task automatic check(string req, logic [NO-1:0] exp);
    checks++;
    if (out_vec !== exp) begin
      errors++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, in_vec, out_vec, exp);
    end
  endtask

  task automatic shift_word(logic [CW-1:0] w);
    for (int b = CW-1; b >= 0; b--) begin
      @(negedge clk); cfg_en = 1'b1; cfg_bit = w[b];
    end
    @(negedge clk); cfg_en = 1'b0; cfg_bit = 1'b0;
  endtask

  task automatic arm();
    cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
  endtask

  task automatic sweep(string req, logic [CW-1:0] w);
    for (int v = 0; v < (1 << NI); v++) begin
      in_vec = v[NI-1:0]; #1;
      check(req, model(w, in_vec));
    end
  endtask

  initial begin
    logic [CW-1:0] ref_w, w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    in_vec = 3'b111; #1;
    check("R6 reset", '0);
    rst_n = 1'b1;

    // R8 reference: t0=AB, t1=BC, t2=AC, t3 empty; out0 = OR t0..t2, out1 = ~(OR t0..t3)
    ref_w = '0;
    ref_w[idx_lit(0,0,0)] = 1; ref_w[idx_lit(0,1,0)] = 1;
    ref_w[idx_lit(1,1,0)] = 1; ref_w[idx_lit(1,2,0)] = 1;
    ref_w[idx_lit(2,0,0)] = 1; ref_w[idx_lit(2,2,0)] = 1;
    for (int t = 0; t < 3; t++) ref_w[idx_sel(0, t)] = 1;
    for (int t = 0; t < 4; t++) ref_w[idx_sel(1, t)] = 1;
    ref_w[1] = 1'b1;
    shift_word(ref_w);
    in_vec = 3'b011; #1;
    check("R6 before done", '0);
    arm();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c, maj;
      in_vec = v[2:0]; #1;
      a = in_vec[0]; b = in_vec[1]; c = in_vec[2];
      maj = (a & b) | (b & c) | (a & c);
      check("R8 majority/complement", {~maj, maj});
    end

    // R7: cfg_bit toggles with cfg_en low; function unchanged
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); cfg_bit = k[0];
    end
    cfg_bit = 1'b0;
    sweep("R7 hold", ref_w);

    // R6: one enable clock blanks the outputs
    @(negedge clk); cfg_en = 1'b1;
    @(negedge clk); cfg_en = 1'b0;
    in_vec = 3'b011; #1;
    check("R6 clear", '0);

    // R3: empty terms with polarity set on out0 only; out1 selects all (empty) terms
    w = '0;
    for (int t = 0; t < NT; t++) begin w[idx_sel(0, t)] = 1; w[idx_sel(1, t)] = 1; end
    w[0] = 1'b1;
    shift_word(w); arm();
    sweep("R3 empty terms", w);

    // R2: contradictory literal on t0, plain B' on t1 to out1
    w = '0;
    w[idx_lit(0,0,0)] = 1; w[idx_lit(0,0,1)] = 1; w[idx_sel(0,0)] = 1;
    w[idx_lit(1,1,1)] = 1; w[idx_sel(1,1)] = 1; w[idx_sel(0,1)] = 1;
    shift_word(w); arm();
    sweep("R2 literals", w);

    // R1 R4 R5: random configurations, exhaustive inputs
    for (int n = 0; n < 40; n++) begin
      w = {$urandom(), $urandom()};
      shift_word(w); arm();
      sweep("R1 R4 R5 random", w);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule